// File: doc/BRIEF.md
# Victim/Aggressor Role Scheduler

This block decides, for each wire of a parallel on-chip bus under crosstalk test, whether that wire is a victim (the wire whose reception is checked) or an aggressor (a neighbour that is toggled to disturb it) in the current test step. One register bit is kept per wire. At any moment several victims are tested side by side. Victims that are active together are always kept a minimum number of wires apart, so that one victim never acts as an aggressor on another.

The register is loaded with a spread-out victim pattern. Each step strobe rotates it by one wire position. The starting pattern is derived from the wire count and the minimum spacing. It uses as many victims as that spacing allows and spreads them as evenly as possible around the ring. As a result, every wire has been a victim after the fewest possible steps, even when the wire count is not a multiple of the spacing. A completion flag tells the surrounding test sequencer when the sweep is over.

Top module: `role_sched`

## Requirements
- R1: `roleVec` carries one bit per wire, with 1 meaning victim and 0 meaning aggressor. After reset it holds the preload pattern. With V = floor(NUM_WIRES / MIN_GAP), that pattern has victims exactly at wire indices floor(i * NUM_WIRES / V) for i = 0 .. V-1, and every other bit is 0.
- R2: At every step, exactly V bits of `roleVec` are 1.
- R3: Any two victims active at the same time lie at least MIN_GAP wires apart. The distance is measured around the ring, so it includes the wrap from the highest wire index back to wire 0.
- R4: A step strobe sampled high on a rising clock edge while `sweepDone` is low rotates the roles at that edge. The new bit j takes the old bit j-1, and the new bit 0 takes the old bit NUM_WIRES-1.
- R5: While `stepStrobe` is low, `roleVec` and `sweepDone` do not change.
- R6: `sweepDone` is high exactly when S-1 strobes have been accepted since reset, with S = ceil(NUM_WIRES / V). By that point every wire has been a victim in at least one of the S patterns shown.
- R7: A strobe that arrives while `sweepDone` is high is ignored. Both `roleVec` and `sweepDone` keep their values.
- R8: Driving the asynchronous active-low reset low at any point reloads the preload pattern and clears `sweepDone`.
- R9: A strobe held high over consecutive cycles advances the pattern by one position on each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| stepStrobe | input | 1 | Request to advance to the next test step |
| roleVec | output | NUM_WIRES | Per-wire role, 1 = victim, 0 = aggressor |
| sweepDone | output | 1 | High once every wire has served as a victim |

## Verification
The assertions expect `stepStrobe` to be a clean synchronous level: it changes only between clock edges, and it can be held high for any number of cycles. The assertions also expect reset to be the only event that restarts a sweep. For that reason, the checker's step counter is cleared only by `rstN`. The stimulus changes every input on the falling clock edge. It applies mid-sweep resets only when rotations have been counted from the previous reset. Strobes during the done state, long idle gaps and back-to-back strobes are all applied, so each of these cases is exercised.

// File: rtl/role_pkg.sv
package role_pkg;

  typedef struct packed {
    logic rotate;
    logic hold;
  } roleStrobes_t;

  function automatic int victimCount(input int nWires, input int minGap);
    int v;
    v = (minGap > 0) ? nWires / minGap : nWires;
    if (v < 1) v = 1;
    return v;
  endfunction

  function automatic int sweepLength(input int nWires, input int minGap);
    int v;
    v = victimCount(nWires, minGap);
    return (nWires + v - 1) / v;
  endfunction

endpackage

// File: rtl/role_ctrl.sv
module role_ctrl
  import role_pkg::*;
#(
  parameter int NUM_WIRES = 16,
  parameter int MIN_GAP   = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         stepStrobe,
  output roleStrobes_t ctrlStrobes,
  output logic         sweepDone
);

  localparam int SWEEP = sweepLength(NUM_WIRES, MIN_GAP);
  localparam int CW    = (SWEEP > 1) ? $clog2(SWEEP) : 1;
  localparam logic [CW-1:0] LAST = CW'(SWEEP - 1);

  logic [CW-1:0] stepIdx;
  logic          atLast;
  logic          accept;

  assign atLast = (stepIdx == LAST);
  assign accept = stepStrobe && !atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (accept) begin
      stepIdx <= stepIdx + CW'(1);
    end
  end

  always_comb begin
    ctrlStrobes.rotate = accept;
    ctrlStrobes.hold   = !accept;
  end

  assign sweepDone = atLast;

endmodule

// File: rtl/role_shift.sv
module role_shift
  import role_pkg::*;
#(
  parameter int NUM_WIRES = 16,
  parameter int MIN_GAP   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  roleStrobes_t         ctrlStrobes,
  output logic [NUM_WIRES-1:0] roleVec
);

  localparam int VICT = victimCount(NUM_WIRES, MIN_GAP);

  function automatic logic [NUM_WIRES-1:0] makePreload();
    logic [NUM_WIRES-1:0] p;
    p = '0;
    for (int i = 0; i < VICT; i++) begin
      p[(i * NUM_WIRES) / VICT] = 1'b1;
    end
    return p;
  endfunction

  localparam logic [NUM_WIRES-1:0] PRELOAD = makePreload();

  logic [NUM_WIRES-1:0] cellQ;
  logic [NUM_WIRES-1:0] cellD;

  for (genvar g = 0; g < NUM_WIRES; g++) begin : g_cell
    localparam int SRC = (g + NUM_WIRES - 1) % NUM_WIRES;
    always_comb begin
      if (ctrlStrobes.rotate && !ctrlStrobes.hold) cellD[g] = cellQ[SRC];
      else                                         cellD[g] = cellQ[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cellQ <= PRELOAD;
    else       cellQ <= cellD;
  end

  assign roleVec = cellQ;

endmodule

// File: rtl/role_sched.sv
module role_sched
  import role_pkg::*;
#(
  parameter int NUM_WIRES = 16,
  parameter int MIN_GAP   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepStrobe,
  output logic [NUM_WIRES-1:0] roleVec,
  output logic                 sweepDone
);

  roleStrobes_t ctrlStrobes;

  role_ctrl #(.NUM_WIRES(NUM_WIRES), .MIN_GAP(MIN_GAP)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .stepStrobe  (stepStrobe),
    .ctrlStrobes (ctrlStrobes),
    .sweepDone   (sweepDone)
  );

  role_shift #(.NUM_WIRES(NUM_WIRES), .MIN_GAP(MIN_GAP)) u_shift (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlStrobes (ctrlStrobes),
    .roleVec     (roleVec)
  );

endmodule

// File: rtl/role_sched_chk.sv
module role_sched_chk
  import role_pkg::*;
#(
  parameter int NUM_WIRES = 16,
  parameter int MIN_GAP   = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 stepStrobe,
  input logic [NUM_WIRES-1:0] roleVec,
  input logic                 sweepDone
);

  localparam int VICT  = victimCount(NUM_WIRES, MIN_GAP);
  localparam int SWEEP = sweepLength(NUM_WIRES, MIN_GAP);

  function automatic int ringGap(input logic [NUM_WIRES-1:0] v);
    int first;
    int prev;
    int g;
    first = -1;
    prev  = -1;
    g     = NUM_WIRES;
    for (int i = 0; i < NUM_WIRES; i++) begin
      if (v[i]) begin
        if (prev >= 0 && (i - prev) < g) g = i - prev;
        if (first < 0) first = i;
        prev = i;
      end
    end
    if (first >= 0 && prev != first && (first + NUM_WIRES - prev) < g)
      g = first + NUM_WIRES - prev;
    return g;
  endfunction

  int taken;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) taken <= 0;
    else if (stepStrobe && taken < SWEEP - 1) taken <= taken + 1;
  end

  a_r2_victim_count: assert property (@(posedge clk) disable iff (!rstN)
    $countones(roleVec) == VICT);

  a_r3_min_gap: assert property (@(posedge clk) disable iff (!rstN)
    ringGap(roleVec) >= MIN_GAP);

  a_r4_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (stepStrobe && !sweepDone) |=>
      roleVec == {$past(roleVec[NUM_WIRES-2:0]), $past(roleVec[NUM_WIRES-1])});

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stepStrobe |=> ($stable(roleVec) && $stable(sweepDone)));

  a_r6_done_timing: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone == (taken == SWEEP - 1));

  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |=> (sweepDone && $stable(roleVec)));

endmodule

bind role_sched role_sched_chk #(.NUM_WIRES(NUM_WIRES), .MIN_GAP(MIN_GAP)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stepStrobe (stepStrobe),
  .roleVec    (roleVec),
  .sweepDone  (sweepDone)
);

// File: tb/role_sched_tb.sv
module role_sched_tb;

  localparam int N     = 16;
  localparam int D     = 3;
  localparam int V     = N / D;
  localparam int S     = (N + V - 1) / V;
  localparam time TCLK = 5ns;

  logic         clk;
  logic         rstN;
  logic         stepStrobe;
  logic [N-1:0] roleVec;
  logic         sweepDone;

  int checks;
  int errors;

  role_sched #(.NUM_WIRES(N), .MIN_GAP(D)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .stepStrobe (stepStrobe),
    .roleVec    (roleVec),
    .sweepDone  (sweepDone)
  );

  initial clk = 1'b0;
  always #(TCLK / 2) clk = ~clk;

  function automatic logic [N-1:0] expPreload();
    logic [N-1:0] p;
    p = '0;
    for (int i = 0; i < V; i++) p[(i * N) / V] = 1'b1;
    return p;
  endfunction

  function automatic logic [N-1:0] rot(input logic [N-1:0] v);
    return {v[N-2:0], v[N-1]};
  endfunction

  function automatic int ringGap(input logic [N-1:0] v);
    int first;
    int prev;
    int g;
    first = -1;
    prev  = -1;
    g     = N;
    for (int i = 0; i < N; i++) begin
      if (v[i]) begin
        if (prev >= 0 && (i - prev) < g) g = i - prev;
        if (first < 0) first = i;
        prev = i;
      end
    end
    if (first >= 0 && prev != first && (first + N - prev) < g) g = first + N - prev;
    return g;
  endfunction

  task automatic chkVec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s roleVec actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s sweepDone actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input int act, input int exp, input bit atLeast);
    checks++;
    if (atLeast ? (act < exp) : (act != exp)) begin
      errors++;
      $display("FAIL %s value actual=%0d expected=%s%0d", req, act, atLeast ? ">=" : "", exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN       = 1'b0;
    stepStrobe = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doStep();
    stepStrobe = 1'b1;
    @(negedge clk);
    stepStrobe = 1'b0;
  endtask

  // R1 R2 R3: reset pattern
  task automatic tReset();
    doReset();
    chkVec("R1", roleVec, expPreload());
    chkBit("R1", sweepDone, (S == 1));
    chkInt("R2", $countones(roleVec), V, 1'b0);
    chkInt("R3", ringGap(roleVec), D, 1'b1);
  endtask

  // R4 R5 R6 R2 R3: full sweep with idle gaps
  task automatic tSweep();
    logic [N-1:0] exp;
    logic [N-1:0] seen;
    doReset();
    exp  = expPreload();
    seen = roleVec;
    for (int k = 1; k < S; k++) begin
      repeat (3) @(negedge clk);
      chkVec("R5", roleVec, exp);
      doStep();
      exp  = rot(exp);
      seen = seen | roleVec;
      chkVec("R4", roleVec, exp);
      chkInt("R2", $countones(roleVec), V, 1'b0);
      chkInt("R3", ringGap(roleVec), D, 1'b1);
      chkBit("R6", sweepDone, (k == S - 1));
    end
    chkVec("R6", seen, '1);
  endtask

  // R7: strobes after completion
  task automatic tAfterDone();
    logic [N-1:0] held;
    held = roleVec;
    for (int k = 0; k < 3; k++) doStep();
    chkVec("R7", roleVec, held);
    chkBit("R7", sweepDone, 1'b1);
  endtask

  // R8: reset in mid-sweep
  task automatic tMidReset();
    doReset();
    doStep();
    chkVec("R8", roleVec, rot(expPreload()));
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chkVec("R8", roleVec, expPreload());
    chkBit("R8", sweepDone, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // R9: strobe held high
  task automatic tHeld();
    logic [N-1:0] exp;
    doReset();
    exp = expPreload();
    stepStrobe = 1'b1;
    for (int k = 1; k < S; k++) begin
      @(negedge clk);
      exp = rot(exp);
      chkVec("R9", roleVec, exp);
    end
    @(negedge clk);
    stepStrobe = 1'b0;
    chkVec("R9", roleVec, exp);
    chkBit("R9", sweepDone, 1'b1);
  endtask

  initial begin
    checks     = 0;
    errors     = 0;
    rstN       = 1'b0;
    stepStrobe = 1'b0;
    tReset();
    tSweep();
    tAfterDone();
    tMidReset();
    tHeld();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(TCLK * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule